// File: doc/BRIEF.md
# Nibble Palette Color Expander

This block turns a packed bitmap, two 4-bit pixel codes per byte, into 24-bit RGB for a raster display. A CPU-side write port loads sixteen byte-wide color registers. Each cycle the block takes the current raster position, forms the byte address in video memory, picks the left or right nibble of the returned byte, looks that code up in the color registers, and widens the 8-bit color to three 8-bit channels with fixed binary weights, the way a resistor ladder would.

Video memory is column-major: the byte column sits in the high address byte and the memory line in the low byte. A visible area of 304 pixels by 240 lines sits inside the output raster. It starts 8 pixels from the left edge and at memory line 6. Everything outside that area is driven black with the valid flag low. Blanking, the memory itself and bus arbitration are outside this block.

Top module: `nib_palette_expander`

## Requirements
- R1: A cycle with `pal_we` high stores `pal_data` into the color register selected by `pal_addr` (0 to 15). No other register changes.
- R2: A color byte carries red in bits 2:0. Red output = 33·bit0 + 71·bit1 + 151·bit2. `rgb_out[23:16]` is red.
- R3: Green is held in color bits 5:3. Green output = 33·bit3 + 71·bit4 + 151·bit5. `rgb_out[15:8]` is green.
- R4: Blue is held in color bits 7:6. Blue output = 71·bit6 + 151·bit7. `rgb_out[7:0]` is blue.
- R5: Within a video byte, bits 7:4 hold the code of the even (left) pixel and bits 3:0 hold the odd (right) pixel.
- R6: For a visible position, the pixel index is px = `ras_x` − 8. `vram_addr` = {px[8:1], (`ras_y` + 6)[7:0]}, so the column byte is in bits 15:8 and the memory line in bits 7:0.
- R7: Only raster lines 0 to 239 are visible. They show memory lines 6 to 245. Lines 240 and up are blank.
- R8: Only `ras_x` from 8 to 311 is visible, which is 304 pixels or 152 byte columns. Other x values are blank.
- R9: A raster position applied in cycle n appears on `rgb_out` and `rgb_valid` after the clock edge that ends cycle n+1, which is two edges. `vram_data` is taken one cycle after `vram_addr`.
- R10: A color-register write takes effect for a raster position applied in the same cycle as the write strobe or later. Positions applied earlier use the old value.
- R11: When `rgb_valid` is low, `rgb_out` is zero.
- R12: Reset clears all color registers to 0 and drives `rgb_valid` low and `rgb_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_we | input | 1 | Color register write strobe |
| pal_addr | input | 4 | Color register index |
| pal_data | input | 8 | Color byte, blue 7:6, green 5:3, red 2:0 |
| ras_x | input | 9 | Raster pixel column |
| ras_y | input | 8 | Raster line |
| vram_addr | output | 16 | Video memory byte address |
| vram_data | input | 8 | Video memory byte, one cycle after address |
| rgb_out | output | 24 | Red 23:16, green 15:8, blue 7:0 |
| rgb_valid | output | 1 | Pixel inside the visible area |

## Verification
The bench builds the block with its default parameters: a 9-bit x, an 8-bit y, 152 columns, an offset of 8 and 240 lines. With these values, full raster rows from x = 0 to 319 reach both horizontal edges (7/8 and 311/312). Rows 0, 239, 240 and 255 reach both vertical edges and the line wrap past 255. Holding one position while all sixteen registers take a single-bit color isolates each channel weight. Writes interleaved with a scan exercise the same-cycle write ordering.

// File: rtl/npx_pkg.sv
package npx_pkg;

  localparam int W_LSB = 33;
  localparam int W_MID = 71;
  localparam int W_MSB = 151;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
  } rgb_t;

  // Weighted sum of a 3-bit ladder, bit 0 lightest.
  function automatic logic [7:0] ladder3(input logic [2:0] code);
    logic [7:0] acc;
    acc = 8'd0;
    if (code[0]) acc = acc + 8'(W_LSB);
    if (code[1]) acc = acc + 8'(W_MID);
    if (code[2]) acc = acc + 8'(W_MSB);
    return acc;
  endfunction

endpackage

// File: rtl/npx_raster_addr.sv
module npx_raster_addr #(
  parameter int X_W        = 9,
  parameter int Y_W        = 8,
  parameter int COLS       = 152,
  parameter int X_OFF      = 8,
  parameter int FIRST_LINE = 6,
  parameter int VIS_LINES  = 240
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [X_W-1:0]                ras_x,
  input  logic [Y_W-1:0]                ras_y,
  output logic [$clog2(COLS)+Y_W-1:0]   vram_addr,
  output logic                          vis_q,
  output logic                          low_nib_q
);

  localparam int COL_W = $clog2(COLS);
  localparam logic [X_W-1:0] X_LO = X_W'(X_OFF);
  localparam logic [X_W-1:0] X_HI = X_W'(X_OFF + 2 * COLS);
  localparam logic [Y_W-1:0] Y_HI = Y_W'(VIS_LINES);
  localparam logic [Y_W-1:0] Y_SH = Y_W'(FIRST_LINE);

  logic [X_W-1:0]   px;
  logic [COL_W-1:0] col;
  logic [Y_W-1:0]   mem_line;
  logic             vis_d;
  logic             low_nib_d;

  always_comb begin
    px        = ras_x - X_LO;
    col       = px[COL_W:1];
    mem_line  = ras_y + Y_SH;
    vram_addr = {col, mem_line};
    vis_d     = (ras_x >= X_LO) && (ras_x < X_HI) && (ras_y < Y_HI);
    low_nib_d = px[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q     <= 1'b0;
      low_nib_q <= 1'b0;
    end else begin
      vis_q     <= vis_d;
      low_nib_q <= low_nib_d;
    end
  end

endmodule

// File: rtl/npx_palette_file.sv
module npx_palette_file #(
  parameter int N_ENT = 16,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [$clog2(N_ENT)-1:0]  waddr,
  input  logic [DW-1:0]             wdata,
  input  logic [$clog2(N_ENT)-1:0]  raddr,
  output logic [DW-1:0]             rdata
);

  logic [DW-1:0] ent_q [N_ENT];

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    logic          en;
    logic [DW-1:0] ent_d;

    always_comb begin
      en    = we && (waddr == ($clog2(N_ENT))'(gi));
      ent_d = en ? wdata : ent_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[gi] <= '0;
      else        ent_q[gi] <= ent_d;
    end
  end

  assign rdata = ent_q[raddr];

endmodule

// File: rtl/npx_color_dac.sv
module npx_color_dac
  import npx_pkg::*;
(
  input  logic [7:0] code,
  output rgb_t       color
);

  logic [2:0] slice [3];
  logic [7:0] level [3];

  always_comb begin
    slice[0] = code[2:0];
    slice[1] = code[5:3];
    slice[2] = {code[7:6], 1'b0};
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign level[ch] = ladder3(slice[ch]);
  end

  assign color = '{red: level[0], grn: level[1], blu: level[2]};

endmodule

// File: rtl/nib_palette_expander.sv
module nib_palette_expander
  import npx_pkg::*;
#(
  parameter int X_W        = 9,
  parameter int Y_W        = 8,
  parameter int COLS       = 152,
  parameter int X_OFF      = 8,
  parameter int FIRST_LINE = 6,
  parameter int VIS_LINES  = 240,
  parameter int N_ENT      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pal_we,
  input  logic [$clog2(N_ENT)-1:0]      pal_addr,
  input  logic [7:0]                    pal_data,
  input  logic [X_W-1:0]                ras_x,
  input  logic [Y_W-1:0]                ras_y,
  output logic [$clog2(COLS)+Y_W-1:0]   vram_addr,
  input  logic [7:0]                    vram_data,
  output logic [23:0]                   rgb_out,
  output logic                          rgb_valid
);

  localparam int IDX_W = $clog2(N_ENT);

  logic             vis_s1;
  logic             low_s1;
  logic [IDX_W-1:0] code_s1;
  logic [7:0]       color_s1;
  rgb_t             dac_s1;
  rgb_t             rgb_d, rgb_q;
  logic             valid_d, valid_q;

  npx_raster_addr #(
    .X_W(X_W), .Y_W(Y_W), .COLS(COLS), .X_OFF(X_OFF),
    .FIRST_LINE(FIRST_LINE), .VIS_LINES(VIS_LINES)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .ras_x(ras_x), .ras_y(ras_y),
    .vram_addr(vram_addr), .vis_q(vis_s1), .low_nib_q(low_s1)
  );

  // Left pixel lives in the upper nibble.
  assign code_s1 = low_s1 ? vram_data[IDX_W-1:0] : vram_data[2*IDX_W-1:IDX_W];

  npx_palette_file #(.N_ENT(N_ENT), .DW(8)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(pal_addr), .wdata(pal_data),
    .raddr(code_s1), .rdata(color_s1)
  );

  npx_color_dac u_dac (.code(color_s1), .color(dac_s1));

  always_comb begin
    valid_d = vis_s1;
    rgb_d   = vis_s1 ? dac_s1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      rgb_q   <= rgb_d;
      valid_q <= valid_d;
    end
  end

  assign rgb_out   = rgb_q;
  assign rgb_valid = valid_q;

endmodule

// File: rtl/npx_checker.sv
module npx_checker #(
  parameter int X_W        = 9,
  parameter int Y_W        = 8,
  parameter int COLS       = 152,
  parameter int X_OFF      = 8,
  parameter int FIRST_LINE = 6,
  parameter int VIS_LINES  = 240
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [X_W-1:0]              ras_x,
  input logic [Y_W-1:0]              ras_y,
  input logic [$clog2(COLS)+Y_W-1:0] vram_addr,
  input logic [23:0]                 rgb_out,
  input logic                        rgb_valid
);

  logic [1:0] age;
  logic       vis_now;
  logic [Y_W-1:0] want_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign vis_now = (int'(ras_x) >= X_OFF) && (int'(ras_x) < X_OFF + 2 * COLS)
                && (int'(ras_y) < VIS_LINES);
  assign want_line = ras_y + Y_W'(FIRST_LINE);

  a_r11_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rgb_valid |-> (rgb_out == 24'd0));

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (rgb_valid == $past(vis_now, 2)));

  a_r4_blue_levels: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |-> (rgb_out[7:0] == 8'd0 || rgb_out[7:0] == 8'd71 ||
                   rgb_out[7:0] == 8'd151 || rgb_out[7:0] == 8'd222));

  a_r6_line_field: assert property (@(posedge clk) disable iff (!rst_n)
    vis_now |-> (vram_addr[Y_W-1:0] == want_line));

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd1) |-> (!rgb_valid && rgb_out == 24'd0));

endmodule

bind nib_palette_expander npx_checker #(
  .X_W(X_W), .Y_W(Y_W), .COLS(COLS), .X_OFF(X_OFF),
  .FIRST_LINE(FIRST_LINE), .VIS_LINES(VIS_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_x(ras_x), .ras_y(ras_y),
  .vram_addr(vram_addr), .rgb_out(rgb_out), .rgb_valid(rgb_valid)
);

// File: tb/nib_palette_expander_test.sv
`timescale 1ns/1ps
module nib_palette_expander_test;

  logic        clk;
  logic        rst_n;
  logic        pal_we;
  logic [3:0]  pal_addr;
  logic [7:0]  pal_data;
  logic [8:0]  ras_x;
  logic [7:0]  ras_y;
  logic [15:0] vram_addr;
  logic [7:0]  vram_data;
  logic [23:0] rgb_out;
  logic        rgb_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit live  = 0;
  string tag = "R12";

  nib_palette_expander uut (
    .clk(clk), .rst_n(rst_n), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_data(pal_data), .ras_x(ras_x), .ras_y(ras_y), .vram_addr(vram_addr),
    .vram_data(vram_data), .rgb_out(rgb_out), .rgb_valid(rgb_valid)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Video memory content as a function of address.
  function automatic int vbyte(int a);
    return ((a >> 8) * 7 + (a & 255) * 13 + 5) & 255;
  endfunction

  function automatic int lvl(int b0, int b1, int b2);
    return (b0 ? 33 : 0) + (b1 ? 71 : 0) + (b2 ? 151 : 0);
  endfunction

  function automatic int expand(int c);
    int r, g, b;
    r = lvl(c & 1, c & 2, c & 4);
    g = lvl(c & 8, c & 16, c & 32);
    b = lvl(0, c & 64, c & 128);
    return (r << 16) | (g << 8) | b;
  endfunction

  function automatic bit visible(int x, int y);
    return (x >= 8) && (x < 312) && (y < 240);
  endfunction

  function automatic int exp_addr(int x, int y);
    return (((x - 8) >> 1) << 8) | ((y + 6) & 255);
  endfunction

  // Memory model: one cycle read latency.
  always @(posedge clk) vram_data <= 8'(vbyte(int'(vram_addr)));

  // Reference model.
  int pal_m [16];
  int p1_x, p1_y;
  int e_rgb;
  bit e_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pal_m[i] = 0;
      p1_x = 0; p1_y = 255; e_rgb = 0; e_val = 0;
    end else begin
      if (visible(p1_x, p1_y)) begin
        int byt, nib;
        byt = vbyte(exp_addr(p1_x, p1_y));
        nib = ((p1_x - 8) % 2 == 0) ? (byt >> 4) : (byt & 15);
        e_rgb = expand(pal_m[nib]);
        e_val = 1;
      end else begin
        e_rgb = 0; e_val = 0;
      end
      p1_x = int'(ras_x);
      p1_y = int'(ras_y);
      if (pal_we) pal_m[pal_addr] = int'(pal_data);
    end
  end

  always @(negedge clk) begin
    if (live) begin
      n_chk++;
      if (rgb_valid !== e_val) begin
        n_bad++;
        $display("FAIL R9 %s valid: got %0b exp %0b", tag, rgb_valid, e_val);
      end
      n_chk++;
      if (rgb_out !== 24'(e_rgb)) begin
        n_bad++;
        if (!e_val) $display("FAIL R11 %s rgb: got %06h exp %06h", tag, rgb_out, e_rgb);
        else        $display("FAIL R5 %s rgb: got %06h exp %06h", tag, rgb_out, e_rgb);
      end
      if (visible(int'(ras_x), int'(ras_y))) begin
        n_chk++;
        if (vram_addr !== 16'(exp_addr(int'(ras_x), int'(ras_y)))) begin
          n_bad++;
          $display("FAIL R6 addr: got %04h exp %04h", vram_addr,
                   exp_addr(int'(ras_x), int'(ras_y)));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    pal_we = 1; pal_addr = 4'(a); pal_data = 8'(d);
    step();
    pal_we = 0;
  endtask

  task automatic scan_row(int y);
    for (int x = 0; x < 320; x++) begin
      ras_x = 9'(x); ras_y = 8'(y);
      step();
    end
  endtask

  task automatic weight(int v, int want, string rq);
    ras_x = 9'd20; ras_y = 8'd50;
    for (int i = 0; i < 16; i++) wr(i, v);
    repeat (3) step();
    @(negedge clk);
    n_chk++;
    if (rgb_out !== 24'(want) || !rgb_valid) begin
      n_bad++;
      $display("FAIL %s color %02h: got %06h exp %06h", rq, v, rgb_out, want);
    end
    #1;
  endtask

  initial begin
    rst_n = 0; pal_we = 0; pal_addr = 0; pal_data = 0; ras_x = 0; ras_y = 0;
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (rgb_valid !== 1'b0 || rgb_out !== 24'd0) begin
      n_bad++;
      $display("FAIL R12 reset: got %0b/%06h exp 0/000000", rgb_valid, rgb_out);
    end
    live = 1;
    step();
    tag = "R12"; scan_row(10);

    tag = "R2";
    weight(8'h01, 24'h210000, "R2");
    weight(8'h02, 24'h470000, "R2");
    weight(8'h04, 24'h970000, "R2");
    weight(8'hFF, 24'hFFFFDE, "R2");
    tag = "R3";
    weight(8'h08, 24'h002100, "R3");
    weight(8'h10, 24'h004700, "R3");
    weight(8'h20, 24'h009700, "R3");
    tag = "R4";
    weight(8'h40, 24'h000047, "R4");
    weight(8'h80, 24'h000097, "R4");
    weight(8'hC0, 24'h0000DE, "R4");

    tag = "R1";
    for (int i = 0; i < 16; i++) wr(i, (i * 37 + 11) & 255);
    tag = "R8"; scan_row(0); scan_row(1); scan_row(100); scan_row(239);
    tag = "R7"; scan_row(240); scan_row(255);

    tag = "R10";
    for (int x = 8; x < 80; x++) begin
      ras_x = 9'(x); ras_y = 8'd120;
      if (x % 3 == 0) begin
        pal_we = 1; pal_addr = 4'(x % 16); pal_data = 8'((x * 53) & 255);
      end else pal_we = 0;
      step();
    end
    pal_we = 0;
    repeat (4) step();
    live = 0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule